// File: doc/BRIEF.md
# Runahead Mode Sequencing Controller

This controller moves a simple in-order core between normal execution and a speculative runahead mode around a level-one cache miss. When a miss arrives in normal mode, it keeps the faulting instruction address and the missing line. It switches into runahead mode and fires a one-cycle pulse so the register file takes a checkpoint. It also requests the missing line unless a request for that line is already in flight.

While runahead lasts, the core keeps executing past the miss only to find more misses, and the results are thrown away. Further instruction, load or store misses do not stall the core. They are queued as prefetch requests in a small FIFO that drops new entries when it is full. Stores may compute addresses and probe the cache, but their memory write enable is forced low. A branch whose source operand carries the invalid mark never raises a flush.

When the fill for the line that started the episode returns, the controller pulses a checkpoint restore and redirects fetch to the saved faulting address. All other fills are ignored.

Top module: `runahead_ctrl`

## Requirements
- R1: A miss (`miss_valid`=1) seen in normal mode puts `runahead_mode` at 1 on the next cycle, and `redirect_pc` then shows the miss's `miss_pc`.
- R2: On entry, `demand_req` is 1 for exactly the one cycle after the miss, with `demand_line` equal to the missing line, but only if `line_pending` was 0 in the miss cycle.
- R3: `ckpt_capture` is a single-cycle pulse in the first runahead cycle, and it never occurs for misses taken during runahead.
- R4: `mem_wr_en` equals `store_valid` in normal mode and is 0 whenever `runahead_mode` is 1.
- R5: A miss during runahead does not stall the core and starts no nested episode: the mode stays 1, `redirect_pc` is unchanged, and the missing line is pushed as a prefetch request.
- R6: The prefetch FIFO holds `PF_DEPTH` (default 4) lines, drains in arrival order through the `pf_valid`/`pf_ready` handshake, and drops new requests while full.
- R7: `br_flush` is `br_valid & (br_pred_taken != br_taken)`, except in runahead mode when `br_src_inv`=1, where it is 0 (the prediction is taken as correct).
- R8: A fill (`fill_valid`=1) whose `fill_line` matches the saved line during runahead makes `runahead_mode` 0 on the next cycle, with `ckpt_restore` and `redirect_valid` each pulsed for that one cycle and `redirect_pc` holding the saved address.
- R9: A fill for any other line during runahead, and any fill in normal mode, has no effect on mode or pulses.
- R10: If the matching fill and a new miss arrive in the same cycle, the exit takes place. That miss is neither queued for prefetch nor used to start a new episode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_valid | input | 1 | Level-one instruction or data miss this cycle |
| miss_pc | input | PC_W | Address of the faulting instruction |
| miss_line | input | LINE_W | Line address that missed |
| line_pending | input | 1 | A fetch for the missing line is already in flight |
| fill_valid | input | 1 | A line fill completed this cycle |
| fill_line | input | LINE_W | Line address of the completed fill |
| store_valid | input | 1 | A store wants to write memory this cycle |
| br_valid | input | 1 | A branch resolves this cycle |
| br_src_inv | input | 1 | The branch source operand is marked invalid |
| br_pred_taken | input | 1 | Predicted direction |
| br_taken | input | 1 | Computed direction |
| pf_ready | input | 1 | Prefetch consumer accepts the head entry |
| runahead_mode | output | 1 | 1 while in runahead mode |
| demand_req | output | 1 | One-cycle demand fetch request |
| demand_line | output | LINE_W | Line to demand-fetch |
| pf_valid | output | 1 | Prefetch FIFO not empty |
| pf_line | output | LINE_W | Head prefetch line |
| mem_wr_en | output | 1 | Store write enable to memory |
| br_flush | output | 1 | Mispredict flush request |
| ckpt_capture | output | 1 | Register file checkpoint capture pulse |
| ckpt_restore | output | 1 | Register file checkpoint restore pulse |
| redirect_valid | output | 1 | Fetch redirect pulse |
| redirect_pc | output | PC_W | Saved faulting address |

## Verification
A wrong mode bit is visible one cycle after the causing input, on the next store (as a write enable leaking through or being blocked) and on the next invalid-operand branch. A corrupted saved line shows as an exit that never happens or happens on the wrong fill, and a corrupted saved address shows in `redirect_pc` at the exit pulse. Mistakes in the FIFO pointers appear only when the queue drains, as a reordered, duplicated or missing `pf_line`. For that reason the bench fills past capacity and drains every entry.

// File: rtl/ra_pkg.sv
// Shared types for the runahead sequencing controller.
package ra_pkg;
    typedef enum logic {
        RA_NORMAL = 1'b0,
        RA_AHEAD  = 1'b1
    } ra_mode_e;
endpackage

// File: rtl/ra_mode_seq.sv
// Mode sequencer: owns the normal/runahead state, the saved miss context and
// the entry/exit pulses. Assumes miss and fill inputs are single-cycle events.
module ra_mode_seq
    import ra_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [LINE_W-1:0] miss_line,
    input  logic              line_pending,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    output logic              in_runahead,
    output logic              capture_pulse,
    output logic              restore_pulse,
    output logic              redirect_pulse,
    output logic [PC_W-1:0]   saved_pc,
    output logic              demand_pulse,
    output logic [LINE_W-1:0] saved_line,
    output logic              pf_push
);
    ra_mode_e state;
    logic     fill_hit;

    // Exit condition: the fill for the line that started this episode.
    always_comb fill_hit = (state == RA_AHEAD) && fill_valid && (fill_line == saved_line);

    // Misses during runahead become prefetches unless the exit wins this cycle.
    always_comb pf_push = (state == RA_AHEAD) && miss_valid && !fill_hit;

    always_comb in_runahead = (state == RA_AHEAD);

    // State transitions, saved context and one-cycle pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state          <= RA_NORMAL;
            saved_pc       <= '0;
            saved_line     <= '0;
            capture_pulse  <= 1'b0;
            restore_pulse  <= 1'b0;
            redirect_pulse <= 1'b0;
            demand_pulse   <= 1'b0;
        end else begin
            capture_pulse  <= 1'b0;
            restore_pulse  <= 1'b0;
            redirect_pulse <= 1'b0;
            demand_pulse   <= 1'b0;
            case (state)
                RA_NORMAL: begin
                    if (miss_valid) begin
                        state         <= RA_AHEAD;
                        saved_pc      <= miss_pc;
                        saved_line    <= miss_line;
                        capture_pulse <= 1'b1;
                        demand_pulse  <= !line_pending;
                    end
                end
                RA_AHEAD: begin
                    if (fill_hit) begin
                        state          <= RA_NORMAL;
                        restore_pulse  <= 1'b1;
                        redirect_pulse <= 1'b1;
                    end
                end
                default: state <= RA_NORMAL;
            endcase
        end
    end

    // R1: entry follows a normal-mode miss and latches its address.
    assert_enter_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RA_NORMAL && miss_valid) |=> (state == RA_AHEAD && saved_pc == $past(miss_pc)));

    // R3: capture is never held for two cycles.
    assert_capture_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        capture_pulse |=> !capture_pulse);

    // R5: no nested episode on a runahead miss.
    assert_no_nest_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == RA_AHEAD && miss_valid && !fill_hit) |=>
            (state == RA_AHEAD && $stable(saved_pc) && !capture_pulse));

    // R8: matching fill exits with restore and redirect.
    assert_exit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fill_hit |=> (state == RA_NORMAL && restore_pulse && redirect_pulse));

    // R10: a miss coinciding with the exit is not queued.
    assert_exit_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_hit && miss_valid) |-> !pf_push);
endmodule

// File: rtl/ra_pf_fifo.sv
// Prefetch request queue: circular buffer of line addresses. Pushes while full
// are dropped; a pop happens when the head is valid and the consumer is ready.
module ra_pf_fifo #(
    parameter int DEPTH  = 4,
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [LINE_W-1:0] push_line,
    input  logic              pop_ready,
    output logic              head_valid,
    output logic [LINE_W-1:0] head_line
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [LINE_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              full, do_push, do_pop;

    // Handshake decode.
    always_comb begin
        full       = (count == FULL_CNT);
        head_valid = (count != '0);
        do_pop     = head_valid && pop_ready;
        do_push    = push && !full;
        head_line  = slots[rd_ptr];
    end

    // Storage write; no reset needed for data.
    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_line;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy never exceeds depth.
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    // R6: a push into a full queue without a pop leaves it full (dropped).
    assert_drop_when_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop_ready) |=> (count == FULL_CNT && $stable(wr_ptr)));
endmodule

// File: rtl/runahead_ctrl.sv
// Top of the runahead sequencing controller. Combines the mode sequencer, the
// prefetch queue, the store write gate and the branch flush filter. Assumes the
// core stalls nothing on misses during runahead and honours the redirect.
module runahead_ctrl
    import ra_pkg::*;
#(
    parameter int PC_W     = 32,
    parameter int LINE_W   = 26,
    parameter int PF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              miss_valid,
    input  logic [PC_W-1:0]   miss_pc,
    input  logic [LINE_W-1:0] miss_line,
    input  logic              line_pending,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              store_valid,
    input  logic              br_valid,
    input  logic              br_src_inv,
    input  logic              br_pred_taken,
    input  logic              br_taken,
    input  logic              pf_ready,
    output logic              runahead_mode,
    output logic              demand_req,
    output logic [LINE_W-1:0] demand_line,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    output logic              mem_wr_en,
    output logic              br_flush,
    output logic              ckpt_capture,
    output logic              ckpt_restore,
    output logic              redirect_valid,
    output logic [PC_W-1:0]   redirect_pc
);
    logic pf_push;

    ra_mode_seq #(.PC_W(PC_W), .LINE_W(LINE_W)) u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .miss_valid     (miss_valid),
        .miss_pc        (miss_pc),
        .miss_line      (miss_line),
        .line_pending   (line_pending),
        .fill_valid     (fill_valid),
        .fill_line      (fill_line),
        .in_runahead    (runahead_mode),
        .capture_pulse  (ckpt_capture),
        .restore_pulse  (ckpt_restore),
        .redirect_pulse (redirect_valid),
        .saved_pc       (redirect_pc),
        .demand_pulse   (demand_req),
        .saved_line     (demand_line),
        .pf_push        (pf_push)
    );

    ra_pf_fifo #(.DEPTH(PF_DEPTH), .LINE_W(LINE_W)) u_pf (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (pf_push),
        .push_line  (miss_line),
        .pop_ready  (pf_ready),
        .head_valid (pf_valid),
        .head_line  (pf_line)
    );

    // Memory writes pass only in normal mode.
    always_comb mem_wr_en = store_valid && !runahead_mode;

    // Flush on mispredict, except invalid-source branches during runahead.
    always_comb br_flush = br_valid && (br_pred_taken != br_taken)
                           && !(runahead_mode && br_src_inv);

    // R4: stores never reach memory while in runahead.
    assert_store_blocked_R4: assert property (@(posedge clk) disable iff (!rst_n)
        runahead_mode |-> !mem_wr_en);

    // R7: invalid-source branches in runahead never flush.
    assert_inv_branch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (runahead_mode && br_valid && br_src_inv) |-> !br_flush);

    // R2: demand request only in the first runahead cycle.
    assert_demand_on_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        demand_req |-> (runahead_mode && ckpt_capture));
endmodule

// File: tb/runahead_ctrl_bench.sv
// Self-checking bench: a vector table walked by one loop, then directed tests.
module runahead_ctrl_bench;
    localparam int PC_W = 16;
    localparam int LW   = 8;

    typedef struct packed {
        logic          miss;
        logic [LW-1:0] mline;
        logic [PC_W-1:0] mpc;
        logic          pend;
        logic          fill;
        logic [LW-1:0] fline;
        logic          st;
        logic          e_wr;
        logic          e_mode;
        logic          e_cap;
        logic          e_dem;
        logic          e_rst;
        logic          e_red;
        logic [PC_W-1:0] e_pc;
    } vec_t;

    // miss mline mpc pend fill fline st | wr mode cap dem rst red pc
    localparam vec_t TBL [10] = '{
        {1'b0,8'h00,16'h0000,1'b0,1'b0,8'h00,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0000},
        {1'b1,8'h10,16'h0100,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,16'h0100},
        {1'b0,8'h00,16'h0000,1'b0,1'b0,8'h00,1'b1, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0100},
        {1'b1,8'h20,16'h0140,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0100},
        {1'b0,8'h00,16'h0000,1'b0,1'b1,8'h20,1'b0, 1'b0,1'b1,1'b0,1'b0,1'b0,1'b0,16'h0100},
        {1'b0,8'h00,16'h0000,1'b0,1'b1,8'h10,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'h0100},
        {1'b0,8'h00,16'h0000,1'b0,1'b0,8'h00,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0100},
        {1'b1,8'h30,16'h0200,1'b1,1'b0,8'h00,1'b0, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,16'h0200},
        {1'b1,8'h40,16'h0240,1'b0,1'b1,8'h30,1'b0, 1'b0,1'b0,1'b0,1'b0,1'b1,1'b1,16'h0200},
        {1'b0,8'h00,16'h0000,1'b0,1'b1,8'h30,1'b1, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,16'h0200}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic miss_valid = 1'b0, line_pending = 1'b0, fill_valid = 1'b0, store_valid = 1'b0;
    logic [PC_W-1:0] miss_pc = '0;
    logic [LW-1:0] miss_line = '0, fill_line = '0;
    logic br_valid = 1'b0, br_src_inv = 1'b0, br_pred_taken = 1'b0, br_taken = 1'b0;
    logic pf_ready = 1'b0;
    logic runahead_mode, demand_req, pf_valid, mem_wr_en, br_flush;
    logic ckpt_capture, ckpt_restore, redirect_valid;
    logic [LW-1:0] demand_line, pf_line;
    logic [PC_W-1:0] redirect_pc;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    runahead_ctrl #(.PC_W(PC_W), .LINE_W(LW), .PF_DEPTH(4)) u_runahead_ctrl (
        .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_pc(miss_pc),
        .miss_line(miss_line), .line_pending(line_pending), .fill_valid(fill_valid),
        .fill_line(fill_line), .store_valid(store_valid), .br_valid(br_valid),
        .br_src_inv(br_src_inv), .br_pred_taken(br_pred_taken), .br_taken(br_taken),
        .pf_ready(pf_ready), .runahead_mode(runahead_mode), .demand_req(demand_req),
        .demand_line(demand_line), .pf_valid(pf_valid), .pf_line(pf_line),
        .mem_wr_en(mem_wr_en), .br_flush(br_flush), .ckpt_capture(ckpt_capture),
        .ckpt_restore(ckpt_restore), .redirect_valid(redirect_valid),
        .redirect_pc(redirect_pc)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        miss_valid = 0; fill_valid = 0; store_valid = 0; line_pending = 0; br_valid = 0;
    endtask

    // One cycle: drive at negedge, then wait past the next rising edge.
    task automatic cyc(input logic m, input logic [LW-1:0] ml, input logic [PC_W-1:0] mp,
                       input logic f, input logic [LW-1:0] fl);
        @(negedge clk);
        idle_inputs();
        miss_valid = m; miss_line = ml; miss_pc = mp; fill_valid = f; fill_line = fl;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; store_valid = 1'b1; #1;
        // Reset state (R1, R4, R6, R8)
        check("R1 reset mode", runahead_mode, 0);
        check("R6 reset empty", pf_valid, 0);
        check("R8 reset pulses", {ckpt_capture, ckpt_restore, redirect_valid, demand_req}, 0);
        check("R4 normal store", mem_wr_en, 1);

        // Vector table: R1 R2 R3 R4 R5 R8 R9 R10
        foreach (TBL[i]) begin
            @(negedge clk);
            idle_inputs();
            miss_valid = TBL[i].miss; miss_line = TBL[i].mline; miss_pc = TBL[i].mpc;
            line_pending = TBL[i].pend; fill_valid = TBL[i].fill; fill_line = TBL[i].fline;
            store_valid = TBL[i].st;
            #1;
            check($sformatf("R4 wr_en vec%0d", i), mem_wr_en, TBL[i].e_wr);
            @(posedge clk); #1;
            check($sformatf("R1/R5/R9 mode vec%0d", i), runahead_mode, TBL[i].e_mode);
            check($sformatf("R3 capture vec%0d", i), ckpt_capture, TBL[i].e_cap);
            check($sformatf("R2 demand vec%0d", i), demand_req, TBL[i].e_dem);
            check($sformatf("R8 restore vec%0d", i), ckpt_restore, TBL[i].e_rst);
            check($sformatf("R8 redirect vec%0d", i), redirect_valid, TBL[i].e_red);
            check($sformatf("R1/R8 redirect_pc vec%0d", i), redirect_pc, TBL[i].e_pc);
            if (TBL[i].e_dem)
                check($sformatf("R2 demand_line vec%0d", i), demand_line, TBL[i].mline);
        end

        // R5/R10: only the runahead miss of line 0x20 was queued
        @(negedge clk); idle_inputs(); #1;
        check("R5 queued prefetch", pf_valid, 1);
        check("R5 queued line", pf_line, 8'h20);
        pf_ready = 1'b1;
        @(posedge clk); #1;
        pf_ready = 1'b0;
        check("R10 no queued exit miss", pf_valid, 0);

        // R6: overflow drops, order preserved
        cyc(1, 8'h50, 16'h0300, 0, 8'h00);
        check("R1 second entry", runahead_mode, 1);
        for (int k = 1; k <= 6; k++) cyc(1, 8'h60 + 8'(k), 16'h0400, 0, 8'h00);
        check("R5 still runahead", runahead_mode, 1);
        check("R5 redirect_pc kept", redirect_pc, 16'h0300);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk); idle_inputs(); pf_ready = 1'b1; #1;
            check($sformatf("R6 valid pop%0d", k), pf_valid, 1);
            check($sformatf("R6 order pop%0d", k), pf_line, 8'h60 + 8'(k));
            @(posedge clk); #1;
        end
        @(negedge clk); pf_ready = 1'b0; #1;
        check("R6 drained after drop", pf_valid, 0);

        // R7: branch filter in runahead and normal mode
        br_valid = 1; br_pred_taken = 1; br_taken = 0; br_src_inv = 1; #1;
        check("R7 inv branch in runahead", br_flush, 0);
        br_src_inv = 0; #1;
        check("R7 valid mispredict in runahead", br_flush, 1);
        br_pred_taken = 0; #1;
        check("R7 correct prediction", br_flush, 0);

        // R9/R8: wrong fill ignored, right fill exits with saved pc
        cyc(0, 8'h00, 16'h0000, 1, 8'h61);
        check("R9 wrong fill ignored", {runahead_mode, ckpt_restore}, 2'b10);
        cyc(0, 8'h00, 16'h0000, 1, 8'h50);
        check("R8 exit", {runahead_mode, ckpt_restore, redirect_valid}, 3'b011);
        check("R8 exit pc", redirect_pc, 16'h0300);
        @(negedge clk); idle_inputs(); br_valid = 1; br_src_inv = 1;
        br_pred_taken = 1; br_taken = 0; #1;
        check("R7 inv ignored in normal", br_flush, 1);
        br_valid = 0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule